// File: doc/BRIEF.md
# Triplicated Memory Majority Voter

This block sits between a processor data port and three replica memory banks that keep identical contents. In the normal voted mode a write places the same word into all three banks, and a read fetches the three copies and returns their bitwise two-of-three majority. Any number of flipped bits confined to one copy is masked. A fault becomes uncorrectable only when the same bit position is flipped in two or more copies.

A two-bit access-mode field, sent with each request, can also steer one request to a single bank. Software uses this to write deliberate faults into one replica, or to read back one replica's raw contents, while the part is in service. Every voted read also reports whether the copies disagreed and which banks differed from the majority.

The three banks are held inside the block as small register arrays, so the read path is combinational through the bank and the voter. One output register sits at the end of that path.

Top module: `tmr_mem_voter`

## Requirements
- R1: After synchronous active-high reset, `rd_valid`, `rd_data`, `rd_mismatch` and `rd_bad_bank` are all zero. Every location of every bank reads back as zero.
- R2: A write with `req_mode` = 2'b00 (voted) stores the identical word at the given address in all three banks.
- R3: A read request (`req_valid`=1, `req_we`=0) drives `rd_valid` high for exactly one cycle, on the clock edge that follows the request. In voted mode `rd_data` is then the bitwise majority of the three copies at that address.
- R4: In a voted read, when one bank differs from the other two in any number of bits, `rd_data` equals the common value of the other two. `rd_bad_bank` is then one-hot on that bank, where bit i stands for bank i.
- R5: In a voted read, when the same bit is flipped in two banks, `rd_data` carries the flipped bit. The bank that kept the original value is the one flagged in `rd_bad_bank`.
- R6: Mode encoding: 2'b01 selects bank 0, 2'b10 selects bank 1, and 2'b11 selects bank 2 for direct access.
- R7: A write in a direct mode changes only the selected bank. The other two banks keep their contents at that address.
- R8: A read in a direct mode returns the selected bank's raw word without voting. `rd_mismatch` and `rd_bad_bank` are zero for that read.
- R9: `rd_mismatch` is high exactly when `rd_bad_bank` is non-zero. It is therefore zero when all three copies are equal, and can flag all three banks when each one differs in a different bit.
- R10: A cycle with no read request leaves `rd_valid` low on the next edge. `rd_data`, `rd_mismatch` and `rd_bad_bank` hold their last read values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe for one cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 00 voted, 01/10/11 direct to bank 0/1/2 |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Voted or raw read word |
| rd_mismatch | output | 1 | Copies disagreed on this read |
| rd_bad_bank | output | 3 | Banks that differ from the majority |

## Verification
The bench builds the block with an 8-bit word and a 4-bit address, which gives 16 locations per bank. With 16 locations, every address used can be tracked in a shadow model, and faults can be planted freely through direct writes. The 8-bit width leaves room for multi-bit faults in one copy, for coincident faults in two copies, and for a case where each of the three copies carries a different bad bit. Back-to-back reads and reads following writes cover the one-cycle latency and the hold behaviour.

// File: rtl/tmv_pkg.sv
package tmv_pkg;

    localparam int unsigned NUM_COPIES = 3;

    typedef enum logic [1:0] {
        ACC_VOTED = 2'b00,
        ACC_BANK0 = 2'b01,
        ACC_BANK1 = 2'b10,
        ACC_BANK2 = 2'b11
    } acc_mode_e;

    // Banks touched by a write in the given mode
    function automatic logic [NUM_COPIES-1:0] write_mask(acc_mode_e m);
        case (m)
            ACC_BANK0: return 3'b001;
            ACC_BANK1: return 3'b010;
            ACC_BANK2: return 3'b100;
            default:   return 3'b111;
        endcase
    endfunction

    // Index of the bank reached in a direct mode
    function automatic int unsigned direct_index(acc_mode_e m);
        return int'(m) - 1;
    endfunction

endpackage

// File: rtl/tmv_bank.sv
module tmv_bank #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/tmv_vote.sv
module tmv_vote
    import tmv_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [NUM_COPIES-1:0][DATA_W-1:0] copies,
    output logic [DATA_W-1:0]                 majority,
    output logic [NUM_COPIES-1:0]             disagree
);
    assign majority = (copies[0] & copies[1]) |
                      (copies[1] & copies[2]) |
                      (copies[0] & copies[2]);

    for (genvar b = 0; b < NUM_COPIES; b++) begin : g_cmp
        assign disagree[b] = |(copies[b] ^ majority);
    end
endmodule

// File: rtl/tmv_route.sv
module tmv_route
    import tmv_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  acc_mode_e                         mode,
    input  logic                              wr_strobe,
    input  logic [NUM_COPIES-1:0][DATA_W-1:0] copies,
    output logic [NUM_COPIES-1:0]             bank_we,
    output logic [DATA_W-1:0]                 raw_word
);
    assign bank_we = wr_strobe ? write_mask(mode) : '0;

    always_comb begin
        raw_word = '0;
        if (mode != ACC_VOTED) raw_word = copies[direct_index(mode)];
    end
endmodule

// File: rtl/tmr_mem_voter.sv
module tmr_mem_voter
    import tmv_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_mismatch,
    output logic [2:0]        rd_bad_bank
);
    typedef struct packed {
        logic [DATA_W-1:0]     word;
        logic [NUM_COPIES-1:0] bad;
    } rd_result_t;

    acc_mode_e                         mode;
    logic [NUM_COPIES-1:0][DATA_W-1:0] copies;
    logic [NUM_COPIES-1:0]             bank_we;
    logic [DATA_W-1:0]                 raw_word;
    logic [DATA_W-1:0]                 voted_word;
    logic [NUM_COPIES-1:0]             disagree;
    logic                              rd_req;
    rd_result_t                        next_res;
    rd_result_t                        res_q;
    logic                              valid_q;

    assign mode   = acc_mode_e'(req_mode);
    assign rd_req = req_valid && !req_we;

    for (genvar b = 0; b < NUM_COPIES; b++) begin : g_bank
        tmv_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) bank_i (
            .clk   (clk),
            .rst   (rst),
            .we    (bank_we[b]),
            .addr  (req_addr),
            .wdata (req_wdata),
            .rdata (copies[b])
        );
    end

    tmv_route #(.DATA_W(DATA_W)) route_i (
        .mode      (mode),
        .wr_strobe (req_valid && req_we),
        .copies    (copies),
        .bank_we   (bank_we),
        .raw_word  (raw_word)
    );

    tmv_vote #(.DATA_W(DATA_W)) vote_i (
        .copies   (copies),
        .majority (voted_word),
        .disagree (disagree)
    );

    always_comb begin
        if (mode == ACC_VOTED) begin
            next_res.word = voted_word;
            next_res.bad  = disagree;
        end else begin
            next_res.word = raw_word;
            next_res.bad  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_req;
            if (rd_req) res_q <= next_res;
        end
    end

    assign rd_valid    = valid_q;
    assign rd_data     = res_q.word;
    assign rd_bad_bank = res_q.bad;
    assign rd_mismatch = |res_q.bad;
endmodule

// File: rtl/tmv_checker.sv
module tmv_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_we,
    input logic [1:0]        req_mode,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_mismatch,
    input logic [2:0]        rd_bad_bank
);
    // R3: a read strobe yields a valid result on the next edge
    a_r3_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we) |=> rd_valid);

    // R10: no read strobe, no valid pulse
    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_we) |=> !rd_valid);

    // R10: outputs hold between reads
    a_r10_data_holds: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_we) |=> ($stable(rd_data) && $stable(rd_bad_bank)));

    // R8: direct reads report no disagreement
    a_r8_direct_clean: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we && req_mode != 2'b00) |=> (rd_bad_bank == 3'b000 && !rd_mismatch));

    // R9: mismatch flag agrees with the bank vector
    a_r9_flag_consistent: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_mismatch == (rd_bad_bank != 3'b000)));
endmodule

bind tmr_mem_voter tmv_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_we      (req_we),
    .req_mode    (req_mode),
    .req_addr    (req_addr),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_mismatch (rd_mismatch),
    .rd_bad_bank (rd_bad_bank)
);

// File: tb/tmr_mem_voter_tb_top.sv
module tmr_mem_voter_tb_top;
    localparam int unsigned DW = 8;
    localparam int unsigned AW = 4;

    typedef struct {
        logic [DW-1:0] d;
        logic          mm;
        logic [2:0]    bb;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [1:0]    req_mode = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          rd_mismatch;
    logic [2:0]    rd_bad_bank;

    int total = 0;
    int bad = 0;
    bit done = 0;

    exp_t sb_q[$];
    logic [DW-1:0] shadow [3][1<<AW];

    always #5 clk = ~clk;

    tmr_mem_voter #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_mismatch(rd_mismatch),
        .rd_bad_bank(rd_bad_bank)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] mode, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_mode = mode;
        req_addr = AW'(a); req_wdata = d;
        if (mode == 2'b00) for (int b = 0; b < 3; b++) shadow[b][a] = d;
        else shadow[int'(mode) - 1][a] = d;
    endtask

    task automatic rd(input logic [1:0] mode, input int a, input string tag);
        exp_t e;
        logic [DW-1:0] c0, c1, c2, m;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_mode = mode; req_addr = AW'(a);
        c0 = shadow[0][a]; c1 = shadow[1][a]; c2 = shadow[2][a];
        m = (c0 & c1) | (c1 & c2) | (c0 & c2);
        if (mode == 2'b00) begin
            e.d  = m;
            e.bb = {c2 != m, c1 != m, c0 != m};
        end else begin
            e.d  = shadow[int'(mode) - 1][a];
            e.bb = 3'b000;
        end
        e.mm  = (e.bb != 3'b000);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    // Monitor: pops expectations as results appear
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && rd_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10 unexpected rd_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(rd_data == e.d, {e.tag, " data"}, rd_data, e.d);
                    check(rd_bad_bank == e.bb, {e.tag, " bad_bank"}, rd_bad_bank, e.bb);
                    check(rd_mismatch == e.mm, {e.tag, " R9 mismatch"}, rd_mismatch, e.mm);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        for (int b = 0; b < 3; b++)
            for (int a = 0; a < (1 << AW); a++) shadow[b][a] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        check(rd_data == '0, "R1 rd_data after reset", rd_data, 0);
        check(rd_bad_bank == 3'b000 && !rd_mismatch, "R1 flags after reset", rd_bad_bank, 0);

        rd(2'b00, 3, "R1 unwritten voted");
        rd(2'b10, 7, "R1 unwritten direct bank1");

        // R2, R6, R8: voted write then raw reads of every bank
        wr(2'b00, 5, 8'hA5);
        rd(2'b01, 5, "R2 R6 bank0 raw");
        rd(2'b10, 5, "R2 R6 bank1 raw");
        rd(2'b11, 5, "R2 R6 bank2 raw");
        rd(2'b00, 5, "R3 clean voted");

        // R7, R4: multi-bit fault in bank1 only
        wr(2'b10, 5, 8'h5A);
        rd(2'b01, 5, "R7 bank0 untouched");
        rd(2'b11, 5, "R7 bank2 untouched");
        rd(2'b10, 5, "R8 bank1 raw faulty");
        rd(2'b00, 5, "R4 corrected bank1 fault");

        // R5: same bit flipped in banks 0 and 2
        wr(2'b00, 9, 8'h3C);
        wr(2'b01, 9, 8'h3D);
        wr(2'b11, 9, 8'h3D);
        rd(2'b00, 9, "R5 coincident flip");

        // R9: every bank wrong in a different bit
        wr(2'b00, 12, 8'h00);
        wr(2'b01, 12, 8'h01);
        wr(2'b10, 12, 8'h02);
        wr(2'b11, 12, 8'h04);
        rd(2'b00, 12, "R9 all banks flagged");

        // R4: bank2 and bank0 single-copy faults elsewhere
        wr(2'b00, 15, 8'hFF);
        wr(2'b11, 15, 8'h0F);
        rd(2'b00, 15, "R4 corrected bank2 fault");
        wr(2'b01, 0, 8'h81);
        rd(2'b00, 0, "R4 bank0 fault on zero word");

        // R10: hold across a write and an idle cycle
        idle();
        @(posedge clk); #1;
        held = rd_data;
        wr(2'b00, 1, 8'h77);
        @(posedge clk); #1;
        check(rd_valid == 1'b0, "R10 no valid after write", rd_valid, 0);
        check(rd_data == held, "R10 data held after write", rd_data, held);
        idle();
        @(posedge clk); #1;
        check(rd_data == held, "R10 data held after idle", rd_data, held);

        rd(2'b00, 1, "R2 voted readback");
        rd(2'b11, 1, "R2 bank2 readback");
        idle();
        repeat (3) @(posedge clk);
        #2;
        check(sb_q.size() == 0, "R3 all reads answered", sb_q.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule